// File: doc/BRIEF.md
# Population count execution unit

This execution-stage unit counts the 1 bits in a source operand of 16, 32 or 64 bits. It returns the count in a 64-bit destination, zero-extended. It also returns a six-bit arithmetic flag vector. Only the bits inside the selected operand width take part in the count.

The decode stage supplies four qualifiers with the operand: whether the core is in 64-bit mode, whether the instruction is enabled, whether a lock prefix was present, and the operand width. From these the unit either produces a result or signals an invalid-opcode fault. Both outcomes are registered and appear on the cycle after the input strobe. A fault leaves the destination and the flags as they were.

Top module: `bitcount_unit`

## Requirements
- R1: With a legal request, `dest` holds the number of 1 bits in `src[N-1:0]`. N is 16 for `size_sel`=00, 32 for 01 and 64 for 10.
- R2: Source bits at position N and above have no effect on `dest` or `flags`.
- R3: Bits 63 down to 7 of `dest` are always zero after a result.
- R4: `flags` bit positions are [0] carry, [1] parity, [2] auxiliary carry, [3] zero, [4] sign, [5] overflow. Every bit except [3] is 0 after each result.
- R5: Flag bit [3] is 1 when `src[N-1:0]` is all zero, and 0 otherwise.
- R6: A request with `feat_en`=0 produces a fault.
- R7: A request with `lock_pfx`=1 produces a fault.
- R8: A 64-bit request (`size_sel`=10) with `long_mode`=0 produces a fault. The unused code `size_sel`=11 also produces a fault.
- R9: On a fault, `fault_valid` pulses instead of `res_valid`, and `dest` and `flags` keep their previous values.
- R10: `res_valid` or `fault_valid` rises exactly one cycle after `in_valid`. Both are low in every other cycle. Reset clears every output to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe |
| src | input | 64 | Source operand |
| size_sel | input | 2 | Operand width: 00=16, 01=32, 10=64, 11 illegal |
| long_mode | input | 1 | Core is in 64-bit mode |
| feat_en | input | 1 | Instruction enabled |
| lock_pfx | input | 1 | Lock prefix present |
| res_valid | output | 1 | Result pulse |
| fault_valid | output | 1 | Invalid-opcode fault pulse |
| dest | output | 64 | Zero-extended count |
| flags | output | 6 | Flag vector, layout per R4 |

## Verification
Operands carry set bits above the selected width. A unit that masks wrongly therefore counts them, or clears the zero flag for a source whose counted part is zero. All-ones operands at each width reach the top of the count range. A truncated adder tree would wrap to zero there and raise a false zero flag. Every fault is issued right after a known result. A unit that wrote on a fault would then show a changed destination or flag vector, and a unit that decoded 64-bit mode loosely would return a count instead of faulting.

// File: rtl/bitcount_unit.sv
module bitcount_unit (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [63:0] src,
  input  logic [1:0]  size_sel,
  input  logic        long_mode,
  input  logic        feat_en,
  input  logic        lock_pfx,
  output logic        res_valid,
  output logic        fault_valid,
  output logic [63:0] dest,
  output logic [5:0]  flags
);
  localparam int W      = 64;
  localparam int LV     = $clog2(W);
  localparam int CW     = LV + 1;
  localparam int ZF_BIT = 3;

  logic [W-1:0]  mask, msrc;
  logic [CW-1:0] tree [0:LV][0:W-1];
  logic [CW-1:0] count;
  logic          illegal, take;

  always_comb begin
    case (size_sel)
      2'b00:   mask = 64'h0000_0000_0000_FFFF;
      2'b01:   mask = 64'h0000_0000_FFFF_FFFF;
      default: mask = '1;
    endcase
  end

  assign msrc = src & mask;

  always_comb begin
    for (int l = 0; l <= LV; l++)
      for (int n = 0; n < W; n++)
        tree[l][n] = '0;
    for (int n = 0; n < W; n++)
      tree[0][n] = CW'(msrc[n]);
    for (int l = 1; l <= LV; l++)
      for (int n = 0; n < (W >> l); n++)
        tree[l][n] = tree[l-1][2*n] + tree[l-1][2*n+1];
  end

  assign count   = tree[LV][0];
  assign illegal = !feat_en || lock_pfx || size_sel == 2'b11 ||
                   (size_sel == 2'b10 && !long_mode);
  assign take    = in_valid && !illegal;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid   <= 1'b0;
      fault_valid <= 1'b0;
      dest        <= '0;
      flags       <= '0;
    end else begin
      res_valid   <= take;
      fault_valid <= in_valid && illegal;
      if (take) begin
        dest          <= {{(64-CW){1'b0}}, count};
        flags         <= '0;
        flags[ZF_BIT] <= (count == '0);
      end
    end
  end
endmodule

module bitcount_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic [63:0] src,
  input logic [1:0]  size_sel,
  input logic        long_mode,
  input logic        feat_en,
  input logic        lock_pfx,
  input logic        res_valid,
  input logic        fault_valid,
  input logic [63:0] dest,
  input logic [5:0]  flags
);
  assert_one_outcome_R10: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (res_valid != fault_valid));
  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!res_valid && !fault_valid));
  assert_zero_ext_R3: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> dest[63:7] == '0);
  assert_status_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (flags & 6'b110111) == '0);
  assert_zero_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> flags[3] == (dest == '0));
  assert_feat_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !feat_en) |=> fault_valid);
  assert_lock_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && lock_pfx) |=> fault_valid);
  assert_wide_mode_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && size_sel == 2'b10 && !long_mode) |=> fault_valid);
  assert_fault_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fault_valid |-> ($stable(dest) && $stable(flags)));
endmodule

bind bitcount_unit bitcount_unit_chk u_chk (.*);

// File: tb/sim_bitcount_unit.sv
module sim_bitcount_unit;
  localparam int PERIOD = 10;

  logic        clk = 0, rst_n = 0, in_valid = 0;
  logic [63:0] src = '0;
  logic [1:0]  size_sel = '0;
  logic        long_mode = 1, feat_en = 1, lock_pfx = 0;
  logic        res_valid, fault_valid;
  logic [63:0] dest;
  logic [5:0]  flags;

  int checks = 0, fails = 0;
  bit done = 0;

  bitcount_unit u0 (.*);

  always #(PERIOD/2) clk = ~clk;

  function automatic int ref_count(input logic [63:0] v, input logic [1:0] sz);
    int w = (sz == 2'b00) ? 16 : (sz == 2'b01) ? 32 : 64;
    int c = 0;
    for (int i = 0; i < w; i++) if (v[i]) c++;
    return c;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [63:0] s, input logic [1:0] sz,
                       input logic lm, input logic fe, input logic lk);
    @(negedge clk);
    src = s; size_sel = sz; long_mode = lm; feat_en = fe; lock_pfx = lk;
    in_valid = 1;
    @(negedge clk);
    in_valid = 0;
  endtask

  task automatic good(input string req, input logic [63:0] s, input logic [1:0] sz);
    int c = ref_count(s, sz);
    issue(s, sz, 1, 1, 0);
    chk({req, " valid"}, {62'b0, res_valid, fault_valid}, 64'b10);
    chk({req, " count R1 R3"}, dest, 64'(c));
    chk({req, " flags R4 R5"}, 64'(flags), (c == 0) ? 64'h8 : 64'h0);
  endtask

  task automatic bad(input string req, input logic [1:0] sz,
                     input logic lm, input logic fe, input logic lk);
    logic [63:0] d0 = dest;
    logic [5:0]  f0 = flags;
    issue(64'hFFFF_0000_1234_5678, sz, lm, fe, lk);
    chk({req, " fault R9"}, {62'b0, res_valid, fault_valid}, 64'b01);
    chk({req, " dest hold R9"}, dest, d0);
    chk({req, " flags hold R9"}, 64'(flags), 64'(f0));
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("reset R10", {res_valid, fault_valid, dest, flags}, '0);
  endtask

  task automatic t_sizes;
    for (int z = 0; z < 3; z++) begin
      good("zero", 64'h0, 2'(z));
      good("ones", '1, 2'(z));
      for (int b = 0; b < 64; b += 9) good("single", 64'h1 << b, 2'(z));
      for (int k = 0; k < 8; k++) good("random", {$urandom, $urandom}, 2'(z));
    end
  endtask

  task automatic t_upper_ignored;
    good("R2 above16", 64'hFFFF_FFFF_FFFF_0000, 2'b00);
    good("R2 above32", 64'hA5A5_0000_0000_0003, 2'b01);
    good("R2 top16", 64'h8000_0000_0001_0000, 2'b00);
  endtask

  task automatic t_faults;
    good("pre", 64'h7, 2'b01);
    bad("R6 feat", 2'b01, 1, 0, 0);
    good("pre", 64'h0, 2'b00);
    bad("R7 lock", 2'b00, 1, 1, 1);
    good("pre", 64'hFF, 2'b10);
    bad("R8 wide legacy", 2'b10, 0, 1, 0);
    bad("R8 code11", 2'b11, 1, 1, 0);
    issue(64'h3, 2'b01, 0, 1, 0);
    chk("R8 32 legacy ok", dest, 64'd2);
  endtask

  task automatic t_gap;
    good("pre", 64'h1, 2'b00);
    @(negedge clk);
    chk("R10 idle", {62'b0, res_valid, fault_valid}, 64'b0);
  endtask

  task automatic finish_up;
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_sizes();
    t_upper_ignored();
    t_faults();
    t_gap();
    finish_up();
  end

  initial begin
    #(PERIOD * 100000);
    checks++; fails++;
    $display("FAIL watchdog R10 actual=hung expected=done");
    finish_up();
  end
endmodule